// File: doc/BRIEF.md
# Parity cache data array with XOR recovery

This block is the data side of a small write-back cache. Each row holds one data word, a set of interleaved parity bits and a dirty flag. Errors are found only by parity, when a row is read. Two running XOR accumulators make a damaged dirty row rebuildable. The first accumulator takes every word written by a store. The second takes every dirty word that goes away, whether it is evicted or overwritten. Each word is rotated by a whole number of bytes, chosen by its row, before it enters either accumulator. A fault that spans neighbouring rows therefore lands in different byte lanes.

The surrounding cache controller drives four operation ports: store, clean fill, evict and read. Accepted reads and evicts answer one cycle later. A read that finds a parity error on a clean row asks for a refetch. A read that finds one on a dirty row reports that the row is fixable. The controller then starts recovery for that row. The recovery engine walks every row, one per cycle. It folds every other dirty row into the XOR of the two accumulators, undoes the target's rotation and writes the rebuilt word back with fresh parity. If the rebuild is impossible, it raises an uncorrectable flag instead. A test-only input flips stored data bits so that faults can be injected.

Top module: `pcx_array`

## Requirements
- R1: After synchronous active-low reset, every row holds zero data with matching parity and is clean, both accumulators are zero, and rec_busy, rec_done, rd_vld and ev_vld are low.
- R2: An accepted store writes st_data into st_row and marks the row dirty. A read of that row returns the new word, even when the row was already dirty.
- R3: An accepted fill writes fill_data into a clean row and leaves the row clean. A fill aimed at a dirty row is ignored, and the row keeps its data.
- R4: An accepted evict raises ev_vld in the next cycle, with ev_data holding the row's word and ev_dirty showing whether the row was dirty. The row is clean afterwards and still holds its data.
- R5: Each word carries P=8 parity bits. Parity bit k is the XOR of the data bits whose index modulo 8 equals k. An accepted read raises rd_vld in the next cycle with rd_data, and rd_perr is set when recomputed parity differs from stored parity. Any burst of 1 to 8 adjacent flipped bits is therefore detected.
- R6: On a read with a parity error, rd_refetch is set if the row is clean and rd_fixable is set if it is dirty. Both are low when there is no parity error.
- R7: The XOR of the two accumulators always equals the XOR of all dirty rows' words, each rotated left by (row mod 4) bytes. Here a store adds its rotated word to the first accumulator, and a dirty row leaving by evict or by store overwrite adds its rotated old word to the second.
- R8: An accepted rec_start raises rec_busy from the next cycle for ROWS+2 cycles, and rec_done is high in the last of those cycles only. If the target row is dirty and no other dirty row has a parity error, the target's word is rebuilt to its last stored value with fresh parity, and rec_ok is set.
- R9: If the target row is clean, or if some other dirty row has a parity error, recovery sets rec_uncorr with rec_done and leaves the target row untouched.
- R10: While rec_busy is high, store, fill, evict, read, flip and rec_start are all ignored. No rd_vld or ev_vld follows, and no row changes except through the recovery write.
- R11: In an idle cycle at most one request is taken, in the priority store, fill, evict, read, flip, rec_start. For example, a store and a read in the same cycle give no rd_vld.
- R12: An accepted flip XORs flip_mask into the row's stored data without updating its parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_row | input | 4 | Store row |
| st_data | input | 32 | Store data |
| fill_valid | input | 1 | Clean fill request |
| fill_row | input | 4 | Fill row |
| fill_data | input | 32 | Fill data |
| ev_valid | input | 1 | Evict request |
| ev_row | input | 4 | Evict row |
| ev_vld | output | 1 | Evict response valid |
| ev_data | output | 32 | Evicted word |
| ev_dirty | output | 1 | Evicted word needs writeback |
| rd_valid | input | 1 | Read request |
| rd_row | input | 4 | Read row |
| rd_vld | output | 1 | Read response valid |
| rd_data | output | 32 | Read word |
| rd_perr | output | 1 | Parity mismatch on read |
| rd_refetch | output | 1 | Clean row damaged, refetch |
| rd_fixable | output | 1 | Dirty row damaged, start recovery |
| flip_valid | input | 1 | Test-only fault injection request |
| flip_row | input | 4 | Row to corrupt |
| flip_mask | input | 32 | Bits to invert |
| rec_start | input | 1 | Start recovery |
| rec_row | input | 4 | Row to rebuild |
| rec_busy | output | 1 | Recovery running, requests stalled |
| rec_done | output | 1 | Recovery finished (one cycle) |
| rec_ok | output | 1 | Row rebuilt |
| rec_uncorr | output | 1 | Row could not be rebuilt |

## Verification
Accumulator corruption is the dangerous failure here. A wrong accumulator stays invisible at the ports until a recovery runs, and then it shows as a wrong rebuilt word on the next read of the target row, possibly thousands of cycles later. The checker compares the accumulators with the dirty rows on every cycle, so a wrong accumulator is flagged one cycle after it goes wrong. Wrong parity or dirty state shows up at the next read or evict of the affected row, one cycle after the request. A wrong recovery sequence shows up as a shifted rec_done or a wrong rec_ok or rec_uncorr.

// File: rtl/pcx_pkg.sv
// Shared types for the parity array with XOR recovery.
// Assumes nothing beyond the enum encoding being private to this block.
package pcx_pkg;
    typedef enum logic [1:0] {
        REC_IDLE = 2'd0,
        REC_SCAN = 2'd1,
        REC_FIX  = 2'd2,
        REC_DONE = 2'd3
    } rec_state_e;
endpackage

// File: rtl/pcx_parity.sv
// Interleaved parity generator: output bit k is the XOR of every data bit
// whose index modulo P equals k.
// Assumes P <= W.
module pcx_parity #(
    parameter int W = 32,
    parameter int P = 8
) (
    input  logic [W-1:0] din,
    output logic [P-1:0] par
);
    for (genvar k = 0; k < P; k++) begin : g_lane
        logic lane_bit;
        // XOR-reduce the bits that belong to lane k
        always_comb begin
            lane_bit = 1'b0;
            for (int i = k; i < W; i += P) begin
                lane_bit ^= din[i];
            end
        end
        assign par[k] = lane_bit;
    end
endmodule

// File: rtl/pcx_byte_rot.sv
// Byte rotator: rotates a word by sel whole bytes, left when LEFT=1 and
// right when LEFT=0.
// Assumes W is a multiple of 8 and 8*(2**SW - 1) < W.
module pcx_byte_rot #(
    parameter int W    = 32,
    parameter int SW   = 2,
    parameter bit LEFT = 1'b1
) (
    input  logic [SW-1:0] sel,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);
    int unsigned sh;

    // convert the byte count into a bit count
    always_comb sh = 8 * int'(sel);

    if (LEFT) begin : g_left
        // rotate toward the MSB
        always_comb dout = (din << sh) | (din >> (W - sh));
    end else begin : g_right
        // rotate toward the LSB
        always_comb dout = (din >> sh) | (din << (W - sh));
    end
endmodule

// File: rtl/pcx_recover.sv
// Recovery sequencer. It seeds a running sum with the XOR of the two
// accumulators. It then visits every row, one per cycle, and folds in the
// rotated word of each dirty, parity-clean row other than the target.
// Finally it asks the array to write the result back.
// Assumes the array contents stay still while busy is high.
module pcx_recover
    import pcx_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int W    = 32,
    parameter int RW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] start_row,
    input  logic          start_dirty,
    input  logic [W-1:0]  acc_x,
    input  logic [W-1:0]  scan_rot,
    input  logic          scan_dirty,
    input  logic          scan_ok,
    output logic [RW-1:0] scan_idx,
    output logic          fix_we,
    output logic [RW-1:0] fix_row,
    output logic [W-1:0]  sum,
    output logic          busy,
    output logic          done,
    output logic          ok,
    output logic          uncorr
);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    rec_state_e    state_q;
    logic [RW-1:0] idx_q;
    logic [RW-1:0] tgt_q;
    logic [W-1:0]  sum_q;
    logic          bad_q;

    // sequence the scan and accumulate the rebuild sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= REC_IDLE;
            idx_q   <= '0;
            tgt_q   <= '0;
            sum_q   <= '0;
            bad_q   <= 1'b0;
        end else begin
            case (state_q)
                REC_IDLE: begin
                    if (start) begin
                        tgt_q   <= start_row;
                        sum_q   <= acc_x;
                        bad_q   <= !start_dirty;
                        idx_q   <= '0;
                        state_q <= REC_SCAN;
                    end
                end
                REC_SCAN: begin
                    if (idx_q != tgt_q && scan_dirty) begin
                        if (scan_ok) begin
                            sum_q <= sum_q ^ scan_rot;
                        end else begin
                            bad_q <= 1'b1;
                        end
                    end
                    if (idx_q == LAST_ROW) begin
                        state_q <= REC_FIX;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                REC_FIX:  state_q <= REC_DONE;
                default:  state_q <= REC_IDLE;
            endcase
        end
    end

    // drive the status and write-back controls from the state
    always_comb begin
        scan_idx = idx_q;
        fix_row  = tgt_q;
        sum      = sum_q;
        busy     = (state_q != REC_IDLE);
        fix_we   = (state_q == REC_FIX) && !bad_q;
        done     = (state_q == REC_DONE);
        ok       = done && !bad_q;
        uncorr   = done && bad_q;
    end
endmodule

// File: rtl/pcx_array.sv
// Data array of a write-back cache with interleaved parity per row and two
// XOR accumulators for rebuilding one damaged dirty row.
// Assumes ROWS and ROT_SPAN are powers of two, W is a multiple of 8 and
// 8*ROT_SPAN <= W. The caller issues at most one request per cycle; extra
// requests are dropped by priority.
module pcx_array #(
    parameter int ROWS     = 16,
    parameter int W        = 32,
    parameter int P        = 8,
    parameter int ROT_SPAN = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     st_valid,
    input  logic [$clog2(ROWS)-1:0]  st_row,
    input  logic [W-1:0]             st_data,
    input  logic                     fill_valid,
    input  logic [$clog2(ROWS)-1:0]  fill_row,
    input  logic [W-1:0]             fill_data,
    input  logic                     ev_valid,
    input  logic [$clog2(ROWS)-1:0]  ev_row,
    output logic                     ev_vld,
    output logic [W-1:0]             ev_data,
    output logic                     ev_dirty,
    input  logic                     rd_valid,
    input  logic [$clog2(ROWS)-1:0]  rd_row,
    output logic                     rd_vld,
    output logic [W-1:0]             rd_data,
    output logic                     rd_perr,
    output logic                     rd_refetch,
    output logic                     rd_fixable,
    input  logic                     flip_valid,
    input  logic [$clog2(ROWS)-1:0]  flip_row,
    input  logic [W-1:0]             flip_mask,
    input  logic                     rec_start,
    input  logic [$clog2(ROWS)-1:0]  rec_row,
    output logic                     rec_busy,
    output logic                     rec_done,
    output logic                     rec_ok,
    output logic                     rec_uncorr
);
    localparam int RW = $clog2(ROWS);
    localparam int SW = $clog2(ROT_SPAN);

    logic [W-1:0]    mem_q [ROWS];
    logic [P-1:0]    par_q [ROWS];
    logic [ROWS-1:0] dirty_q;
    logic [W-1:0]    acc_wr_q;
    logic [W-1:0]    acc_ev_q;

    logic op_st, op_fill, fill_take, op_ev, op_rd, op_flip, op_rec, leave;
    logic wr_en, fix_we;
    logic [RW-1:0] touch_row, wr_row, scan_idx, fix_row;
    logic [W-1:0]  old_rot, new_rot, scan_rot, fix_word, sum_w, wr_word, rd_word, scan_word;
    logic [P-1:0]  wr_par, rd_par, scan_par;

    // decode one request per idle cycle by fixed priority
    always_comb begin
        op_st     = st_valid && !rec_busy;
        op_fill   = fill_valid && !rec_busy && !st_valid;
        fill_take = op_fill && !dirty_q[fill_row];
        op_ev     = ev_valid && !rec_busy && !st_valid && !fill_valid;
        op_rd     = rd_valid && !rec_busy && !st_valid && !fill_valid && !ev_valid;
        op_flip   = flip_valid && !rec_busy && !st_valid && !fill_valid
                    && !ev_valid && !rd_valid;
        op_rec    = rec_start && !rec_busy && !st_valid && !fill_valid
                    && !ev_valid && !rd_valid && !flip_valid;
    end

    // select the row whose old word may leave, and the write source
    always_comb begin
        touch_row = st_valid ? st_row : (fill_valid ? fill_row : ev_row);
        leave     = (op_st || op_ev) && dirty_q[touch_row];
        wr_en     = op_st || fill_take || fix_we;
        wr_row    = fix_we ? fix_row : touch_row;
        wr_word   = fix_we ? fix_word : (op_st ? st_data : fill_data);
        rd_word   = mem_q[rd_row];
        scan_word = mem_q[scan_idx];
    end

    pcx_byte_rot #(.W(W), .SW(SW), .LEFT(1'b1)) u_rot_new (
        .sel(st_row[SW-1:0]), .din(st_data), .dout(new_rot)
    );
    pcx_byte_rot #(.W(W), .SW(SW), .LEFT(1'b1)) u_rot_old (
        .sel(touch_row[SW-1:0]), .din(mem_q[touch_row]), .dout(old_rot)
    );
    pcx_byte_rot #(.W(W), .SW(SW), .LEFT(1'b1)) u_rot_scan (
        .sel(scan_idx[SW-1:0]), .din(scan_word), .dout(scan_rot)
    );
    pcx_byte_rot #(.W(W), .SW(SW), .LEFT(1'b0)) u_rot_fix (
        .sel(fix_row[SW-1:0]), .din(sum_w), .dout(fix_word)
    );

    pcx_parity #(.W(W), .P(P)) u_par_wr   (.din(wr_word),   .par(wr_par));
    pcx_parity #(.W(W), .P(P)) u_par_rd   (.din(rd_word),   .par(rd_par));
    pcx_parity #(.W(W), .P(P)) u_par_scan (.din(scan_word), .par(scan_par));

    pcx_recover #(.ROWS(ROWS), .W(W), .RW(RW)) u_rec (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (op_rec),
        .start_row   (rec_row),
        .start_dirty (dirty_q[rec_row]),
        .acc_x       (acc_wr_q ^ acc_ev_q),
        .scan_rot    (scan_rot),
        .scan_dirty  (dirty_q[scan_idx]),
        .scan_ok     (scan_par == par_q[scan_idx]),
        .scan_idx    (scan_idx),
        .fix_we      (fix_we),
        .fix_row     (fix_row),
        .sum         (sum_w),
        .busy        (rec_busy),
        .done        (rec_done),
        .ok          (rec_ok),
        .uncorr      (rec_uncorr)
    );

    // write data and parity, and apply test-only bit flips to data only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem_q[r] <= '0;
                par_q[r] <= '0;
            end
        end else begin
            if (wr_en) begin
                mem_q[wr_row] <= wr_word;
                par_q[wr_row] <= wr_par;
            end
            if (op_flip) begin
                mem_q[flip_row] <= mem_q[flip_row] ^ flip_mask;
            end
        end
    end

    // track which rows hold data not yet written back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= '0;
        end else if (op_st) begin
            dirty_q[st_row] <= 1'b1;
        end else if (op_ev) begin
            dirty_q[ev_row] <= 1'b0;
        end
    end

    // fold stored words and departing dirty words into the accumulators
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_wr_q <= '0;
            acc_ev_q <= '0;
        end else begin
            if (op_st) acc_wr_q <= acc_wr_q ^ new_rot;
            if (leave) acc_ev_q <= acc_ev_q ^ old_rot;
        end
    end

    // register read and evict responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld     <= 1'b0;
            rd_data    <= '0;
            rd_perr    <= 1'b0;
            rd_refetch <= 1'b0;
            rd_fixable <= 1'b0;
            ev_vld     <= 1'b0;
            ev_data    <= '0;
            ev_dirty   <= 1'b0;
        end else begin
            rd_vld     <= op_rd;
            rd_data    <= rd_word;
            rd_perr    <= op_rd && (rd_par != par_q[rd_row]);
            rd_refetch <= op_rd && (rd_par != par_q[rd_row]) && !dirty_q[rd_row];
            rd_fixable <= op_rd && (rd_par != par_q[rd_row]) && dirty_q[rd_row];
            ev_vld     <= op_ev;
            ev_data    <= mem_q[ev_row];
            ev_dirty   <= op_ev && dirty_q[ev_row];
        end
    end
endmodule

// File: rtl/pcx_array_chk.sv
// Assertion checker for pcx_array, attached by bind. It recomputes the
// accumulator invariant from the array contents. It stops checking the
// invariant for good once a damaged dirty word has been evicted or
// overwritten, since the accumulators then hold damaged data by design.
module pcx_array_chk #(
    parameter int ROWS     = 16,
    parameter int W        = 32,
    parameter int P        = 8,
    parameter int ROT_SPAN = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    st_valid,
    input logic [$clog2(ROWS)-1:0] st_row,
    input logic                    fill_valid,
    input logic [$clog2(ROWS)-1:0] fill_row,
    input logic                    ev_valid,
    input logic [$clog2(ROWS)-1:0] ev_row,
    input logic                    rd_valid,
    input logic                    rec_busy,
    input logic                    rd_vld,
    input logic                    rd_perr,
    input logic                    rd_refetch,
    input logic                    rd_fixable,
    input logic                    ev_vld,
    input logic                    rec_done,
    input logic                    rec_ok,
    input logic                    rec_uncorr,
    input logic [W-1:0]            acc_wr_q,
    input logic [W-1:0]            acc_ev_q,
    input logic [W-1:0]            mem_q [ROWS],
    input logic [P-1:0]            par_q [ROWS],
    input logic [ROWS-1:0]         dirty_q
);
    function automatic logic [P-1:0] f_par(input logic [W-1:0] d);
        logic [P-1:0] p = '0;
        for (int i = 0; i < W; i++) p[i % P] ^= d[i];
        return p;
    endfunction

    function automatic logic [W-1:0] f_rot(input logic [W-1:0] d, input int r);
        int sh = 8 * (r % ROT_SPAN);
        return (d << sh) | (d >> (W - sh));
    endfunction

    logic [W-1:0]    dirty_x;
    logic [ROWS-1:0] row_bad;
    logic            all_good;
    logic            taint_q;

    // rebuild the expected accumulator XOR from the dirty rows
    always_comb begin
        dirty_x  = '0;
        all_good = 1'b1;
        for (int r = 0; r < ROWS; r++) begin
            row_bad[r] = dirty_q[r] && (f_par(mem_q[r]) != par_q[r]);
            if (dirty_q[r]) dirty_x ^= f_rot(mem_q[r], r);
            if (row_bad[r]) all_good = 1'b0;
        end
    end

    // remember when a damaged dirty word has left the array
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taint_q <= 1'b0;
        end else if (!rec_busy && st_valid && row_bad[st_row]) begin
            taint_q <= 1'b1;
        end else if (!rec_busy && !fill_valid && ev_valid && row_bad[ev_row]) begin
            taint_q <= 1'b1;
        end
    end

    assert_xor_invariant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!taint_q && all_good) |-> ((acc_wr_q ^ acc_ev_q) == dirty_x));

    assert_store_dirty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !rec_busy) |=> dirty_q[$past(st_row)]);

    assert_fill_dirty_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !st_valid && !rec_busy && dirty_q[fill_row])
        |=> (mem_q[$past(fill_row)] == $past(mem_q[fill_row])));

    assert_evict_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !st_valid && !fill_valid && !rec_busy) |=> !dirty_q[$past(ev_row)]);

    assert_flag_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_refetch || rd_fixable) |-> (rd_vld && rd_perr && !(rd_refetch && rd_fixable)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |=> !rec_done);

    assert_done_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> rec_busy);

    assert_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_ok || rec_uncorr) |-> (rec_done && (rec_ok != rec_uncorr)));

    assert_stall_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rec_busy |=> ($stable(acc_wr_q) && $stable(acc_ev_q) && $stable(dirty_q)));

    assert_stall_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rec_busy |=> (!rd_vld && !ev_vld));

    assert_one_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && rd_valid) |=> !rd_vld);
endmodule

bind pcx_array pcx_array_chk #(
    .ROWS(ROWS), .W(W), .P(P), .ROT_SPAN(ROT_SPAN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_row     (st_row),
    .fill_valid (fill_valid),
    .fill_row   (fill_row),
    .ev_valid   (ev_valid),
    .ev_row     (ev_row),
    .rd_valid   (rd_valid),
    .rec_busy   (rec_busy),
    .rd_vld     (rd_vld),
    .rd_perr    (rd_perr),
    .rd_refetch (rd_refetch),
    .rd_fixable (rd_fixable),
    .ev_vld     (ev_vld),
    .rec_done   (rec_done),
    .rec_ok     (rec_ok),
    .rec_uncorr (rec_uncorr),
    .acc_wr_q   (acc_wr_q),
    .acc_ev_q   (acc_ev_q),
    .mem_q      (mem_q),
    .par_q      (par_q),
    .dirty_q    (dirty_q)
);

// File: tb/tb_pcx_array.sv
`timescale 1ns/1ps
module tb_pcx_array;
    localparam int ROWS = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        st_valid, fill_valid, ev_valid, rd_valid, flip_valid, rec_start;
    logic [3:0]  st_row, fill_row, ev_row, rd_row, flip_row, rec_row;
    logic [31:0] st_data, fill_data, flip_mask;
    logic        ev_vld, ev_dirty, rd_vld, rd_perr, rd_refetch, rd_fixable;
    logic [31:0] ev_data, rd_data;
    logic        rec_busy, rec_done, rec_ok, rec_uncorr;

    always #2 clk = ~clk;

    pcx_array dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_row(st_row), .st_data(st_data),
        .fill_valid(fill_valid), .fill_row(fill_row), .fill_data(fill_data),
        .ev_valid(ev_valid), .ev_row(ev_row),
        .ev_vld(ev_vld), .ev_data(ev_data), .ev_dirty(ev_dirty),
        .rd_valid(rd_valid), .rd_row(rd_row),
        .rd_vld(rd_vld), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_refetch(rd_refetch), .rd_fixable(rd_fixable),
        .flip_valid(flip_valid), .flip_row(flip_row), .flip_mask(flip_mask),
        .rec_start(rec_start), .rec_row(rec_row),
        .rec_busy(rec_busy), .rec_done(rec_done), .rec_ok(rec_ok), .rec_uncorr(rec_uncorr)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // behavioural reference state
    logic [31:0] m_data [ROWS];
    logic [31:0] m_good [ROWS];
    logic [7:0]  m_par  [ROWS];
    bit          m_dirty [ROWS];
    int          m_cnt;
    bit          m_pend_ok;

    function automatic logic [7:0] ref_par(input logic [31:0] d);
        logic [7:0] p = '0;
        for (int i = 0; i < 32; i++) p[i % 8] ^= d[i];
        return p;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        st_valid = 0; fill_valid = 0; ev_valid = 0; rd_valid = 0;
        flip_valid = 0; rec_start = 0;
        st_row = 0; fill_row = 0; ev_row = 0; rd_row = 0; flip_row = 0; rec_row = 0;
        st_data = 0; fill_data = 0; flip_mask = 0;
    endtask

    // one clock: predict from the driven inputs, then compare at the falling edge
    task automatic tick(input string tag);
        bit e_rd, e_ev, e_perr, e_ev_dirty;
        logic [31:0] e_rd_data, e_ev_data;
        e_rd = 0; e_ev = 0; e_perr = 0; e_ev_dirty = 0;
        e_rd_data = '0; e_ev_data = '0;
        if (m_cnt > 0) begin
            m_cnt--;
        end else if (st_valid) begin
            m_data[st_row] = st_data; m_good[st_row] = st_data;
            m_par[st_row] = ref_par(st_data); m_dirty[st_row] = 1;
        end else if (fill_valid) begin
            if (!m_dirty[fill_row]) begin
                m_data[fill_row] = fill_data; m_good[fill_row] = fill_data;
                m_par[fill_row] = ref_par(fill_data);
            end
        end else if (ev_valid) begin
            e_ev = 1; e_ev_data = m_data[ev_row]; e_ev_dirty = m_dirty[ev_row];
            m_dirty[ev_row] = 0;
        end else if (rd_valid) begin
            e_rd = 1; e_rd_data = m_data[rd_row];
            e_perr = (ref_par(m_data[rd_row]) != m_par[rd_row]);
            e_ev_dirty = m_dirty[rd_row];
        end else if (flip_valid) begin
            m_data[flip_row] = m_data[flip_row] ^ flip_mask;
        end else if (rec_start) begin
            bit bad = !m_dirty[rec_row];
            for (int r = 0; r < ROWS; r++) begin
                if (r != int'(rec_row) && m_dirty[r] && ref_par(m_data[r]) != m_par[r]) bad = 1;
            end
            if (!bad) begin
                m_data[rec_row] = m_good[rec_row];
                m_par[rec_row] = ref_par(m_good[rec_row]);
            end
            m_pend_ok = !bad;
            m_cnt = ROWS + 2;
        end
        @(negedge clk);
        chk({tag, " R8 R10 busy"}, 32'(rec_busy), 32'(m_cnt != 0));
        chk({tag, " R8 done"}, 32'(rec_done), 32'(m_cnt == 1));
        chk({tag, " R8 ok"}, 32'(rec_ok), 32'(m_cnt == 1 && m_pend_ok));
        chk({tag, " R9 uncorr"}, 32'(rec_uncorr), 32'(m_cnt == 1 && !m_pend_ok));
        chk({tag, " R5 R10 R11 rd_vld"}, 32'(rd_vld), 32'(e_rd));
        chk({tag, " R4 R10 ev_vld"}, 32'(ev_vld), 32'(e_ev));
        if (e_rd) begin
            chk({tag, " R2 R3 R5 rd_data"}, rd_data, e_rd_data);
            chk({tag, " R5 rd_perr"}, 32'(rd_perr), 32'(e_perr));
            chk({tag, " R6 rd_refetch"}, 32'(rd_refetch), 32'(e_perr && !e_ev_dirty));
            chk({tag, " R6 rd_fixable"}, 32'(rd_fixable), 32'(e_perr && e_ev_dirty));
        end
        if (e_ev) begin
            chk({tag, " R4 ev_data"}, ev_data, e_ev_data);
            chk({tag, " R4 ev_dirty"}, 32'(ev_dirty), 32'(e_ev_dirty));
        end
        clear_inputs();
    endtask

    task automatic do_store(input int r, input logic [31:0] d, input string tag);
        st_valid = 1; st_row = 4'(r); st_data = d; tick(tag);
    endtask
    task automatic do_fill(input int r, input logic [31:0] d, input string tag);
        fill_valid = 1; fill_row = 4'(r); fill_data = d; tick(tag);
    endtask
    task automatic do_evict(input int r, input string tag);
        ev_valid = 1; ev_row = 4'(r); tick(tag);
    endtask
    task automatic do_read(input int r, input string tag);
        rd_valid = 1; rd_row = 4'(r); tick(tag);
    endtask
    task automatic do_flip(input int r, input logic [31:0] m, input string tag);
        flip_valid = 1; flip_row = 4'(r); flip_mask = m; tick(tag);
    endtask
    task automatic do_recover(input int r, input string tag);
        rec_start = 1; rec_row = 4'(r); tick(tag);
        repeat (ROWS + 2) tick(tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            failures++;
            $display("FAIL R8 watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst_n = 0;
        for (int r = 0; r < ROWS; r++) begin
            m_data[r] = '0; m_good[r] = '0; m_par[r] = '0; m_dirty[r] = 0;
        end
        m_cnt = 0; m_pend_ok = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick("R1 idle after reset");
        do_read(7, "R1 reset row");

        for (int r = 0; r < ROWS; r++) do_fill(r, 32'h5A5A_0000 + 32'(r) * 32'h0001_1111, "R3 fill");
        for (int r = 0; r < ROWS; r++) do_read(r, "R3 R5 clean read");
        for (int r = 0; r < 8; r++) do_store(r, 32'hC000_0000 ^ (32'(r) * 32'h0123_4567), "R2 store");
        do_store(3, 32'hDEAD_BEEF, "R2 R7 overwrite dirty");
        do_read(3, "R2 overwritten");
        do_evict(1, "R4 dirty evict");
        do_evict(1, "R4 clean evict");
        do_evict(12, "R4 never dirty");
        do_fill(2, 32'h0, "R3 fill dirty ignored");
        do_read(2, "R3 dirty kept");
        do_fill(1, 32'h1357_9BDF, "R3 refill");
        do_read(1, "R3 refill read");

        st_valid = 1; st_row = 9; st_data = 32'h0BAD_F00D;
        rd_valid = 1; rd_row = 9;
        tick("R11 store beats read");
        do_read(9, "R11 store taken");

        do_flip(5, 32'h0000_0003, "R12 adjacent pair");
        do_read(5, "R5 R6 pair detected");
        do_recover(5, "R8 single fault");
        do_read(5, "R8 rebuilt word");

        do_flip(6, 32'h0000_FF00, "R12 byte burst");
        rec_start = 1; rec_row = 6; tick("R8 start");
        do_store(10, 32'hFFFF_0000, "R10 store stalled");
        do_read(0, "R10 read stalled");
        do_flip(11, 32'h1, "R10 flip stalled");
        do_evict(0, "R10 evict stalled");
        do_fill(12, 32'h1, "R10 fill stalled");
        rec_start = 1; rec_row = 0; tick("R10 restart stalled");
        repeat (ROWS + 2 - 6) tick("R8 burst fault");
        do_read(6, "R8 burst rebuilt");
        do_read(10, "R10 store was dropped");
        do_read(11, "R10 flip was dropped");
        do_evict(0, "R10 evict was dropped");

        do_flip(12, 32'h8000_0000, "R12 clean row");
        do_read(12, "R6 clean refetch");
        do_recover(12, "R9 clean target");
        do_read(12, "R9 target untouched");
        do_fill(12, 32'h2468_ACE0, "R3 repair clean");

        do_flip(2, 32'h00F0_0000, "R12 row two");
        do_flip(4, 32'h0000_000C, "R12 row four");
        do_read(4, "R6 dirty fixable");
        do_recover(2, "R9 two faults");
        do_read(2, "R9 still damaged");
        do_flip(4, 32'h0000_000C, "R12 undo four");
        do_flip(2, 32'h00F0_0000, "R12 undo two");
        do_recover(2, "R7 R8 clean rebuild");
        do_read(2, "R7 R8 value kept");
        do_read(7, "R7 untouched row");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule